// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask and Routing Controller

This block gathers a fixed set of level-sensitive device interrupt lines, filters them through a master mask and delivers them to one processor chosen by a target register. Each processor also owns a private set of software interrupt bits and a tick input. Every processor gets a 4-bit interrupt level: the highest pending, unmasked level among its soft bits, its tick, and the device sources when it is the selected target.

Software reaches the block over a simple 32-bit word-addressed register bus with a combinational read path. Each processor has a block of three words: pending (read), clear (write-one), set (write-one). These blocks come first, then one master block of five words. In the master block, the set and clear words act on mask bits. A one written to set disables a source. A one written to clear enables it. Bits written as zero never have an effect.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every implemented mask bit is one (mask word reads 0xF07FFF80), the target is processor 0, all soft bits are zero and every level output is 0.
- R2: A write to the master clear word (master offset 2) clears each implemented mask bit written as one and leaves all other mask bits unchanged.
- R3: A write to the master set word (master offset 3) sets each implemented mask bit written as one and leaves all other mask bits unchanged.
- R4: While mask bit 31 is one, every processor's level output is 0.
- R5: The master pending word (master offset 0) shows the device inputs without latching and regardless of the mask. Input k appears at bit 7+k for k in 0..15, and inputs 16, 17, 18 appear at bits 28, 29, 30.
- R6: A write to a processor's set word (offset 1 is clear, offset 2 is set, within block c at word 4c) sets soft level x, stored at bit 16+x, for every bit 17..31 written as one. It has no effect on other processors or on bits written as zero.
- R7: A write to a processor's clear word clears soft level x for every bit 17..31 written as one, with no effect on zero bits.
- R8: Clear and set words, per-processor offset 3 and master offsets above 4 read as zero.
- R9: The target word (master offset 4) reads back the last value written, in its low bits. Unmasked device sources appear only in the selected processor's pending word (hard level x at bit x) and level.
- R10: A processor's tick input appears at bit 14 of its own pending word and drives level 14.
- R11: The level is the highest pending level among hard and soft bits. Device levels: bit 7+j gives level j+1 for j in 0..6; keyboard (bit 14) and serial (bit 15) give 12; Ethernet (bit 16) gives 6; audio (bit 17) gives 13; SCSI (bit 18) gives 4; system timer (bit 19) gives 10; video (bit 20) gives 8; module (bit 21) gives 5; floppy (bit 22) gives 11; bits 28..30 give 15.
- R12: A device source whose mask bit is one contributes to no processor's pending word or level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| dev_irq | input | 19 | Level-sensitive device interrupt lines |
| tick | input | NCPU | Per-processor tick lines |
| level | output | 4*NCPU | Interrupt level per processor, processor c in bits 4c+3:4c |

## Verification
The mask bits, the soft bits and the target are the only state in the block. A wrong value in any of them shows up at a level output as soon as an active source touches it, in the same cycle, because the outputs are combinational from that state. The bench compares every level output on every clock and every read against a behavioural model. A corrupted mask or soft bit is therefore caught on the first cycle a matching source is active, or on the next readback. A wrong target shows up as the device level appearing on the wrong processor.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int          NSRC       = 19;
    localparam logic [31:0] MASK_IMPL  = 32'hF07F_FF80;
    localparam int          MASK_ALL_POS = 31;
    localparam int          TICK_LEVEL = 14;

    typedef enum logic [2:0] {
        MR_PEND = 3'd0,
        MR_MASK = 3'd1,
        MR_CLR  = 3'd2,
        MR_SET  = 3'd3,
        MR_TGT  = 3'd4,
        MR_NONE = 3'd7
    } mreg_e;

    typedef enum logic [1:0] {
        CR_PEND = 2'd0,
        CR_CLR  = 2'd1,
        CR_SET  = 2'd2,
        CR_NONE = 2'd3
    } creg_e;

    // bit position of device source i in the master words
    function automatic int src_pos(input int i);
        return (i < 16) ? (7 + i) : (12 + i);
    endfunction

    // fixed processor level of device source i
    function automatic logic [3:0] src_level(input int i);
        logic [3:0] l;
        if (i < 7) begin
            l = 4'(i + 1);
        end else begin
            case (i)
                7, 8:        l = 4'd12;
                9:           l = 4'd6;
                10:          l = 4'd13;
                11:          l = 4'd4;
                12:          l = 4'd10;
                13:          l = 4'd8;
                14:          l = 4'd5;
                15:          l = 4'd11;
                default:     l = 4'd15;
            endcase
        end
        return l;
    endfunction

    function automatic logic [3:0] top_level(input logic [15:1] v);
        logic [3:0] r;
        r = 4'd0;
        for (int k = 1; k <= 15; k++) begin
            if (v[k]) r = 4'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode import irqc_pkg::*; #(
    parameter int NCPU = 4,
    parameter int AW   = 5,
    localparam int CW  = AW - 2
) (
    input  logic [AW-1:0] addr,
    output logic          is_cpu,
    output logic [CW-1:0] cpu_idx,
    output creg_e         creg,
    output mreg_e         mreg
);
    localparam int CPU_WORDS = NCPU * 4;

    logic [AW-1:0] off;

    always_comb begin
        is_cpu  = 1'b0;
        cpu_idx = addr[AW-1:2];
        creg    = CR_NONE;
        mreg    = MR_NONE;
        off     = addr - AW'(CPU_WORDS);
        if (int'(addr) < CPU_WORDS) begin
            is_cpu = 1'b1;
            case (addr[1:0])
                2'd0:    creg = CR_PEND;
                2'd1:    creg = CR_CLR;
                2'd2:    creg = CR_SET;
                default: creg = CR_NONE;
            endcase
        end else begin
            case (int'(off))
                0:       mreg = MR_PEND;
                1:       mreg = MR_MASK;
                2:       mreg = MR_CLR;
                3:       mreg = MR_SET;
                4:       mreg = MR_TGT;
                default: mreg = MR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irqc_master.sv
module irqc_master import irqc_pkg::*; #(
    parameter int TW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_stb,
    input  logic            set_stb,
    input  logic            tgt_stb,
    input  logic [31:0]     wdata,
    output logic [31:0]     mask_o,
    output logic [NSRC-1:0] dev_en,
    output logic            mask_all,
    output logic [TW-1:0]   tgt_o
);
    logic [31:0]   mask_q;
    logic [TW-1:0] tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= MASK_IMPL;
            tgt_q  <= '0;
        end else begin
            if (clr_stb) mask_q <= mask_q & ~(wdata & MASK_IMPL);
            else if (set_stb) mask_q <= mask_q | (wdata & MASK_IMPL);
            if (tgt_stb) tgt_q <= wdata[TW-1:0];
        end
    end

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            dev_en[i] = ~mask_q[src_pos(i)];
        end
    end

    assign mask_o   = mask_q;
    assign mask_all = mask_q[MASK_ALL_POS];
    assign tgt_o    = tgt_q;

    AST_CLR_ENABLES: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> ((mask_q & $past(wdata & MASK_IMPL)) == 32'h0)); // R2
    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata)))); // R2
    AST_SET_DISABLES: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> ((mask_q & $past(wdata & MASK_IMPL)) == $past(wdata & MASK_IMPL))); // R3
    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!clr_stb && !set_stb) |=> $stable(mask_q)); // R3
    AST_TGT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tgt_stb |=> $stable(tgt_q)); // R9

endmodule

// File: rtl/irqc_route.sv
module irqc_route import irqc_pkg::*; (
    input  logic [NSRC-1:0] dev_irq,
    input  logic [NSRC-1:0] dev_en,
    output logic [15:1]     dev_lvl
);
    always_comb begin
        dev_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (dev_irq[i] && dev_en[i]) dev_lvl[src_level(i)] = 1'b1;
        end
    end
endmodule

// File: rtl/irqc_cpu.sv
module irqc_cpu import irqc_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  logic        set_stb,
    input  logic        clr_stb,
    input  logic [15:1] wsoft,
    input  logic        tick,
    input  logic [15:1] dev_lvl,
    input  logic        is_tgt,
    input  logic        mask_all,
    output logic [31:0] pend_o,
    output logic [3:0]  level_o
);
    logic [15:1] soft_q;
    logic [15:1] hard;

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_q <= '0;
        end else if (set_stb) begin
            soft_q <= soft_q | wsoft;
        end else if (clr_stb) begin
            soft_q <= soft_q & ~wsoft;
        end
    end

    always_comb begin
        hard = is_tgt ? dev_lvl : '0;
        hard[TICK_LEVEL] = hard[TICK_LEVEL] | tick;
    end

    assign pend_o  = {soft_q, 1'b0, hard, 1'b0};
    assign level_o = mask_all ? 4'd0 : top_level(hard | soft_q);

    AST_SOFT_SET: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> ((soft_q & $past(wsoft)) == $past(wsoft))); // R6
    AST_SOFT_CLR: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> ((soft_q & $past(wsoft)) == 15'h0)); // R7
    AST_SOFT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(soft_q)); // R6
    AST_TICK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (tick && !mask_all) |-> (level_o >= 4'd14)); // R10

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl import irqc_pkg::*; #(
    parameter int NCPU = 4,
    parameter int AW   = $clog2(NCPU * 4 + 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   dev_irq,
    input  logic [NCPU-1:0]   tick,
    output logic [NCPU*4-1:0] level
);
    localparam int CW = AW - 2;
    localparam int TW = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic          is_cpu;
    logic [CW-1:0] cpu_idx;
    creg_e         creg;
    mreg_e         mreg;
    logic          wr;

    logic [31:0]     mask_rd;
    logic [NSRC-1:0] dev_en;
    logic            mask_all;
    logic [TW-1:0]   tgt;
    logic [15:1]     dev_lvl;
    logic [31:0]     raw_src;
    logic [31:0]     cpu_pend [NCPU];

    assign wr = bus_sel & bus_we;

    irqc_decode #(.NCPU(NCPU), .AW(AW)) u_dec (
        .addr    (bus_addr),
        .is_cpu  (is_cpu),
        .cpu_idx (cpu_idx),
        .creg    (creg),
        .mreg    (mreg)
    );

    irqc_master #(.TW(TW)) u_master (
        .clk      (clk),
        .rst      (rst),
        .clr_stb  (wr && !is_cpu && mreg == MR_CLR),
        .set_stb  (wr && !is_cpu && mreg == MR_SET),
        .tgt_stb  (wr && !is_cpu && mreg == MR_TGT),
        .wdata    (bus_wdata),
        .mask_o   (mask_rd),
        .dev_en   (dev_en),
        .mask_all (mask_all),
        .tgt_o    (tgt)
    );

    irqc_route u_route (
        .dev_irq (dev_irq),
        .dev_en  (dev_en),
        .dev_lvl (dev_lvl)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic hit;
        assign hit = wr && is_cpu && (cpu_idx == CW'(c));
        irqc_cpu u_cpu (
            .clk      (clk),
            .rst      (rst),
            .set_stb  (hit && creg == CR_SET),
            .clr_stb  (hit && creg == CR_CLR),
            .wsoft    (bus_wdata[31:17]),
            .tick     (tick[c]),
            .dev_lvl  (dev_lvl),
            .is_tgt   (tgt == TW'(c)),
            .mask_all (mask_all),
            .pend_o   (cpu_pend[c]),
            .level_o  (level[c*4 +: 4])
        );
    end

    always_comb begin
        raw_src = '0;
        for (int i = 0; i < NSRC; i++) begin
            raw_src[src_pos(i)] = dev_irq[i];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (is_cpu) begin
                if (creg == CR_PEND) begin
                    for (int c = 0; c < NCPU; c++) begin
                        if (cpu_idx == CW'(c)) bus_rdata = cpu_pend[c];
                    end
                end
            end else begin
                case (mreg)
                    MR_PEND: bus_rdata = raw_src;
                    MR_MASK: bus_rdata = mask_rd;
                    MR_TGT:  bus_rdata = 32'(tgt);
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (level == '0)); // R1

endmodule

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;
    localparam int NCPU = 4;
    localparam int AW   = $clog2(NCPU * 4 + 8);
    localparam int MB   = NCPU * 4;
    localparam int A_PEND = MB, A_MASK = MB + 1, A_CLR = MB + 2, A_SET = MB + 3, A_TGT = MB + 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [18:0] dev_irq = '0;
    logic [NCPU-1:0] tick = '0;
    logic [NCPU*4-1:0] level;

    irq_route_ctrl #(.NCPU(NCPU)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_irq(dev_irq), .tick(tick), .level(level)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit [31:0] m_mask;
    int        m_tgt;
    bit [15:0] m_soft [NCPU];
    logic [18:0]     nd = '0;
    logic [NCPU-1:0] nt = '0;

    function automatic int pos_of(int i);
        return (i < 16) ? 7 + i : 12 + i;
    endfunction

    function automatic int lvl_of(int p);
        if (p >= 7 && p <= 13) return p - 6;
        case (p)
            14, 15: return 12;
            16: return 6;
            17: return 13;
            18: return 4;
            19: return 10;
            20: return 8;
            21: return 5;
            22: return 11;
            default: return 15;
        endcase
    endfunction

    function automatic bit [15:0] m_hard(int c);
        bit [15:0] h = 0;
        if (m_tgt == c)
            for (int i = 0; i < 19; i++)
                if (nd[i] && !m_mask[pos_of(i)]) h[lvl_of(pos_of(i))] = 1;
        if (nt[c]) h[14] = 1;
        return h;
    endfunction

    function automatic int m_level(int c);
        bit [15:0] v;
        if (m_mask[31]) return 0;
        v = m_hard(c) | m_soft[c];
        for (int k = 15; k >= 1; k--) if (v[k]) return k;
        return 0;
    endfunction

    function automatic bit [31:0] m_read(int a);
        bit [31:0] r = 0;
        if (a < MB) begin
            if (a % 4 == 0) r = {m_soft[a/4] & 16'hFFFE, m_hard(a/4) & 16'hFFFE};
        end else begin
            case (a - MB)
                0: for (int i = 0; i < 19; i++) r[pos_of(i)] = nd[i];
                1: r = m_mask;
                4: r = 32'(m_tgt);
                default: r = 0;
            endcase
        end
        return r;
    endfunction

    task automatic m_write(int a, bit [31:0] wd);
        if (a < MB) begin
            if (a % 4 == 1) m_soft[a/4] = m_soft[a/4] & ~(wd[31:16] & 16'hFFFE);
            if (a % 4 == 2) m_soft[a/4] = m_soft[a/4] | (wd[31:16] & 16'hFFFE);
        end else begin
            case (a - MB)
                2: m_mask = m_mask & ~(wd & 32'hF07F_FF80);
                3: m_mask = m_mask | (wd & 32'hF07F_FF80);
                4: m_tgt = int'(wd) & (NCPU - 1);
                default: ;
            endcase
        end
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit sel, input bit we, input int a, input logic [31:0] wd, input string tag);
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = AW'(a); bus_wdata = wd;
        dev_irq = nd; tick = nt;
        #1;
        for (int c = 0; c < NCPU; c++)
            check(32'(level[c*4 +: 4]), 32'(m_level(c)), $sformatf("%s level cpu%0d", tag, c));
        if (sel && !we) check(bus_rdata, m_read(a), $sformatf("%s read @%0d", tag, a));
        @(posedge clk);
        if (sel && we) m_write(a, wd);
    endtask

    task automatic wr_(int a, logic [31:0] d, string tag); step(1, 1, a, d, tag); endtask
    task automatic rd_(int a, string tag); step(1, 0, a, 0, tag); endtask
    task automatic idle(string tag); step(0, 0, 0, 0, tag); endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_mask = 32'hF07F_FF80; m_tgt = 0;
        for (int c = 0; c < NCPU; c++) m_soft[c] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd_(A_MASK, "R1 mask");
        rd_(A_TGT, "R1 target");
        rd_(0, "R1 pend cpu0");

        // R2 enable by clearing mask-all
        wr_(A_CLR, 32'h8000_0000, "R2 clear maskall");
        rd_(A_MASK, "R2 mask");

        // R6 soft set with junk low bits, R7 clear
        wr_(1*4 + 2, 32'h0008_FFFF, "R6 set soft3 cpu1");
        idle("R6 level cpu1");
        rd_(1*4, "R6 pend cpu1");
        wr_(2*4 + 2, 32'h8000_0000, "R6 set soft15 cpu2");
        rd_(2*4, "R6 pend cpu2");
        wr_(1*4 + 1, 32'h0000_0000, "R7 clear zero");
        rd_(1*4, "R7 pend after zero clear");
        wr_(1*4 + 1, 32'h0008_0000, "R7 clear soft3");
        rd_(1*4, "R7 pend cpu1");
        wr_(2*4 + 1, 32'hFFFF_FFFF, "R7 clear all cpu2");

        // R5 / R12 masked timer visible raw only
        nd = 19'h0; nd[12] = 1'b1;
        rd_(A_PEND, "R5 raw timer");
        rd_(0, "R12 pend cpu0 masked");
        wr_(A_CLR, 32'h0008_0000, "R2 enable timer");
        rd_(0, "R11 timer level10 cpu0");

        // R9 target
        wr_(A_TGT, 32'h2, "R9 target 2");
        rd_(A_TGT, "R9 target read");
        rd_(2*4, "R9 pend cpu2");
        rd_(0, "R9 pend cpu0 empty");

        // R10 tick
        nt = 4'b1000;
        rd_(3*4, "R10 tick cpu3");
        nt = 4'b0100;
        idle("R10 tick over timer cpu2");
        nt = 0;

        // R4 mask-all
        wr_(A_SET, 32'h8000_0000, "R4 set maskall");
        wr_(2*4 + 2, 32'hFFFE_0000, "R4 soft under maskall");
        rd_(A_MASK, "R3 mask read");
        wr_(A_CLR, 32'h8000_0000, "R4 release");
        wr_(2*4 + 1, 32'hFFFE_0000, "R7 clear cpu2");

        // R11 each source singly
        wr_(A_CLR, 32'hFFFF_FFFF, "R2 enable all");
        wr_(A_TGT, 32'h1, "R9 target 1");
        for (int i = 0; i < 19; i++) begin
            nd = 19'h0; nd[i] = 1'b1;
            rd_(4, $sformatf("R11 source %0d", i));
        end
        nd = 19'h7FFFF;
        rd_(A_PEND, "R5 all raw");
        wr_(A_SET, 32'h7000_0000, "R3 mask errors");
        idle("R12 errors masked");
        wr_(A_SET, 32'h0040_0000, "R3 mask floppy");
        idle("R11 next highest");
        nd = 0;

        // R8 write-only and unmapped
        rd_(A_CLR, "R8 clear word");
        rd_(A_SET, "R8 set word");
        rd_(MB + 5, "R8 unmapped");
        rd_(1, "R8 cpu clear word");
        rd_(3, "R8 cpu gap");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int a;
            logic [31:0] d;
            nd = 19'($urandom);
            nt = NCPU'($urandom);
            a = $urandom_range(0, MB + 6);
            d = $urandom;
            if ($urandom_range(0, 3) == 0) d = d & 32'h7FFF_FFFF;
            step(1, $urandom_range(0, 1) == 1, a, d, "R11 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule